// File: doc/BRIEF.md
# Masked Vector Lane Execution Unit

This block is a single-lane vector execution engine with its own small register file of signed integer vectors, a vector-length register and a per-element Boolean mask. Each accepted instruction sweeps elements 0 up to the current length, one element per clock. Three instructions are provided: a subtract of two vector registers into a third, a compare of one vector register against a scalar that rewrites the mask, and a clear that fills the mask with ones.

With mask control enabled on a subtract, only destination elements whose mask bit is one receive the difference. The others keep their old contents. This supports the usual pattern for a loop that contains a condition: build the mask from a compare against zero, then run the arithmetic under that mask. Instructions start on a `start` strobe while the unit is idle and end with a one-cycle `done` pulse. A simple element write port and a registered element read port let a testbench load and inspect the register file while the unit is idle.

Top module: `vmask_lane_unit`

## Requirements
- R1: After reset the unit is idle (`busy` and `done` low), the vector length reads MVL (default 64) and every mask bit is one.
- R2: A length write larger than MVL stores MVL; a value from 0 to MVL is stored unchanged.
- R3: Opcode 2 or 3 (mask clear) sets all MVL mask bits to one, whatever their previous value.
- R4: Opcode 1 (compare) sets mask bit i to 1 when element i of the first source differs from `scalar` and to 0 when it equals it, for every i below the length, whatever the current mask and `mask_en`.
- R5: A compare leaves mask bits at index length and above unchanged, and the mask never changes while no instruction is accepted or running.
- R6: Opcode 0 (subtract) with `mask_en` low writes first source minus second source into element i of the destination for every i below the length, wrapping modulo 2^ELEM_W.
- R7: A subtract with `mask_en` high writes only elements whose mask bit is one; elements whose mask bit is zero keep their previous value.
- R8: Elements at index length and above of the destination are not written by a subtract.
- R9: With length 0 an instruction other than a clear writes nothing and still completes with a `done` pulse.
- R10: Counting the accepting edge as edge 0, `done` is high for exactly one cycle after edge length+1, or after edge 1 for a clear or length 0; `start` while `busy` is ignored.
- R11: Comparing X against zero and then subtracting Y from X under the mask into X leaves zero elements of X at zero and replaces every other element with X minus Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction; taken only when idle |
| op | input | 2 | 0 subtract, 1 compare not-equal against scalar, 2/3 mask clear |
| dst_sel | input | log2(NREGS) | Destination register of a subtract |
| srca_sel | input | log2(NREGS) | First source (minuend, or compare source) |
| srcb_sel | input | log2(NREGS) | Second source (subtrahend) |
| scalar | input | ELEM_W | Scalar operand of the compare |
| mask_en | input | 1 | Gate subtract writeback by the mask |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| vl_we | input | 1 | Write the vector-length register |
| vl_wdata | input | log2(MVL+1) | New vector length, saturated to MVL |
| vl_q | output | log2(MVL+1) | Current vector length |
| mask_q | output | MVL | Mask register, bit i for element i |
| rf_we | input | 1 | Load one element (ignored while busy) |
| rf_wreg | input | log2(NREGS) | Register of the loaded element |
| rf_wel | input | log2(MVL) | Index of the loaded element |
| rf_wdata | input | ELEM_W | Loaded element value |
| rf_rreg | input | log2(NREGS) | Register of the inspected element |
| rf_rel | input | log2(MVL) | Index of the inspected element |
| rf_rdata | output | ELEM_W | Inspected element, one cycle after its address |

## Verification
The bench targets the elements a wrong design would touch: masked-off elements and elements past a shortened length. A design that ignored the mask or read a stale length would overwrite values that the scoreboard expects to survive. Subtractions that cross the most negative and most positive values catch a saturating or sign-extending datapath. A compare issued under an enabled mask that holds zeros exposes an engine that skips masked elements during compares. A clear strobed in the middle of a masked subtract, and the exact `done` latency for full, short and zero lengths, catch a unit that accepts work while busy, drops its last element or pulses `done` for more than one cycle.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

  typedef enum logic [1:0] {
    OP_SUB   = 2'd0,
    OP_CMPNE = 2'd1,
    OP_MCLR  = 2'd2,
    OP_MCLRB = 2'd3
  } vop_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } seq_st_e;

  function automatic logic op_is_clear(input logic [1:0] code);
    return code[1];
  endfunction

endpackage

// File: rtl/vlane_rf.sv
// Element register file: one write port, NRD synchronous read ports.
// Each read port owns a replica so that every copy maps onto a simple
// dual-port block RAM.
module vlane_rf #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 9,
  parameter int NRD    = 3
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              waddr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NRD-1:0][ADDR_W-1:0]     raddr,
  output logic [NRD-1:0][DATA_W-1:0]     rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar p = 0; p < NRD; p++) begin : g_copy
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata[p] <= mem[raddr[p]];
    end
  end
endmodule

// File: rtl/vlane_mask.sv
// Per-element mask register. Clear has priority over a compare write.
module vlane_mask #(
  parameter int MVL    = 64,
  parameter int EIDX_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              set_en,
  input  logic [EIDX_W-1:0] set_idx,
  input  logic              set_val,
  input  logic [EIDX_W-1:0] sel_idx,
  output logic              sel_bit,
  output logic [MVL-1:0]    mask_q
);
  for (genvar i = 0; i < MVL; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr)
        mask_q[i] <= 1'b1;
      else if (set_en && (set_idx == EIDX_W'(i)))
        mask_q[i] <= set_val;
    end
  end

  assign sel_bit = mask_q[sel_idx];
endmodule

// File: rtl/vlane_seq.sv
// Element sequencer: issues indices 0..len-1, tracks the read stage and
// produces the completion pulse.
module vlane_seq import vlane_pkg::*; #(
  parameter int MVL    = 64,
  parameter int EIDX_W = 6,
  parameter int LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              no_work,
  input  logic [LEN_W-1:0]  len_in,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic [EIDX_W-1:0] issue_idx,
  output logic              s1_valid,
  output logic [EIDX_W-1:0] s1_idx
);
  seq_st_e          st;
  logic [LEN_W-1:0] len_q;
  logic             last;

  assign accept    = start && (st == ST_IDLE);
  assign busy      = (st != ST_IDLE);
  assign last      = (LEN_W'(issue_idx) + LEN_W'(1)) == len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      issue_idx <= '0;
      len_q     <= '0;
      s1_valid  <= 1'b0;
      s1_idx    <= '0;
      done      <= 1'b0;
    end else begin
      done     <= (st == ST_DRAIN) || (st == ST_FIN);
      s1_valid <= (st == ST_RUN);
      s1_idx   <= issue_idx;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            if (no_work) begin
              st <= ST_FIN;
            end else begin
              st        <= ST_RUN;
              issue_idx <= '0;
              len_q     <= len_in;
            end
          end
        end
        ST_RUN: begin
          if (last) st <= ST_DRAIN;
          else      issue_idx <= issue_idx + EIDX_W'(1);
        end
        ST_DRAIN: st <= ST_IDLE;
        ST_FIN:   st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vmask_lane_unit.sv
// Masked vector lane: subtract, compare-against-scalar and mask clear,
// one element per clock over the programmed vector length.
module vmask_lane_unit import vlane_pkg::*; #(
  parameter int ELEM_W = 16,
  parameter int MVL    = 64,
  parameter int NREGS  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [1:0]                  op,
  input  logic [$clog2(NREGS)-1:0]    dst_sel,
  input  logic [$clog2(NREGS)-1:0]    srca_sel,
  input  logic [$clog2(NREGS)-1:0]    srcb_sel,
  input  logic [ELEM_W-1:0]           scalar,
  input  logic                        mask_en,
  output logic                        busy,
  output logic                        done,
  input  logic                        vl_we,
  input  logic [$clog2(MVL+1)-1:0]    vl_wdata,
  output logic [$clog2(MVL+1)-1:0]    vl_q,
  output logic [MVL-1:0]              mask_q,
  input  logic                        rf_we,
  input  logic [$clog2(NREGS)-1:0]    rf_wreg,
  input  logic [$clog2(MVL)-1:0]      rf_wel,
  input  logic [ELEM_W-1:0]           rf_wdata,
  input  logic [$clog2(NREGS)-1:0]    rf_rreg,
  input  logic [$clog2(MVL)-1:0]      rf_rel,
  output logic [ELEM_W-1:0]           rf_rdata
);
  localparam int RIDX_W = $clog2(NREGS);
  localparam int EIDX_W = $clog2(MVL);
  localparam int LEN_W  = $clog2(MVL+1);
  localparam int ADDR_W = RIDX_W + EIDX_W;
  localparam int NRD    = 3;
  localparam int RP_A   = 0;
  localparam int RP_B   = 1;
  localparam int RP_TB  = 2;

  // Instruction latch
  vop_e              op_q;
  logic [RIDX_W-1:0] dst_q, srca_q, srcb_q;
  logic [ELEM_W-1:0] scalar_q;
  logic              men_q;

  logic              accept, no_work, clr_go;
  logic [EIDX_W-1:0] issue_idx, s1_idx;
  logic              s1_valid;
  logic              sel_bit;

  assign no_work = op_is_clear(op) || (vl_q == '0);
  assign clr_go  = accept && op_is_clear(op);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_SUB;
      dst_q    <= '0;
      srca_q   <= '0;
      srcb_q   <= '0;
      scalar_q <= '0;
      men_q    <= 1'b0;
    end else if (accept) begin
      op_q     <= vop_e'(op);
      dst_q    <= dst_sel;
      srca_q   <= srca_sel;
      srcb_q   <= srcb_sel;
      scalar_q <= scalar;
      men_q    <= mask_en;
    end
  end

  // Vector-length register with saturation at MVL
  always_ff @(posedge clk) begin
    if (rst)
      vl_q <= LEN_W'(MVL);
    else if (vl_we)
      vl_q <= (vl_wdata > LEN_W'(MVL)) ? LEN_W'(MVL) : vl_wdata;
  end

  vlane_seq #(
    .MVL    (MVL),
    .EIDX_W (EIDX_W),
    .LEN_W  (LEN_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .no_work   (no_work),
    .len_in    (vl_q),
    .accept    (accept),
    .busy      (busy),
    .done      (done),
    .issue_idx (issue_idx),
    .s1_valid  (s1_valid),
    .s1_idx    (s1_idx)
  );

  // Register file
  logic [NRD-1:0][ADDR_W-1:0] raddr;
  logic [NRD-1:0][ELEM_W-1:0] rdata;
  logic                       mem_we, wb_sub, cmp_go;
  logic [ADDR_W-1:0]          waddr;
  logic [ELEM_W-1:0]          wdata, diff;

  assign raddr[RP_A]  = {srca_q, issue_idx};
  assign raddr[RP_B]  = {srcb_q, issue_idx};
  assign raddr[RP_TB] = {rf_rreg, rf_rel};

  assign diff   = rdata[RP_A] - rdata[RP_B];
  assign wb_sub = s1_valid && (op_q == OP_SUB) && (!men_q || sel_bit);
  assign cmp_go = s1_valid && (op_q == OP_CMPNE);

  always_comb begin
    if (wb_sub) begin
      mem_we = 1'b1;
      waddr  = {dst_q, s1_idx};
      wdata  = diff;
    end else begin
      mem_we = rf_we && !busy;
      waddr  = {rf_wreg, rf_wel};
      wdata  = rf_wdata;
    end
  end

  vlane_rf #(
    .DATA_W (ELEM_W),
    .ADDR_W (ADDR_W),
    .NRD    (NRD)
  ) u_rf (
    .clk   (clk),
    .we    (mem_we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign rf_rdata = rdata[RP_TB];

  vlane_mask #(
    .MVL    (MVL),
    .EIDX_W (EIDX_W)
  ) u_mask (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_go),
    .set_en  (cmp_go),
    .set_idx (s1_idx),
    .set_val (rdata[RP_A] != scalar_q),
    .sel_idx (s1_idx),
    .sel_bit (sel_bit),
    .mask_q  (mask_q)
  );
endmodule

// File: rtl/vlane_chk.sv
// Protocol checker bound to the lane unit.
module vlane_chk #(
  parameter int MVL   = 64,
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [1:0]       op,
  input logic             busy,
  input logic             done,
  input logic [LEN_W-1:0] vl_q,
  input logic [MVL-1:0]   mask_q
);
  AST_VL_BOUND: assert property (@(posedge clk) disable iff (rst)
    vl_q <= LEN_W'(MVL)); // R2

  AST_CLR_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (op == 2'd2 || op == 2'd3)) |=> (&mask_q)); // R3

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(mask_q)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy || done)); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
endmodule

bind vmask_lane_unit vlane_chk #(
  .MVL   (MVL),
  .LEN_W ($clog2(MVL+1))
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .op     (op),
  .busy   (busy),
  .done   (done),
  .vl_q   (vl_q),
  .mask_q (mask_q)
);

// File: tb/sim_vmask_lane_unit.sv
`timescale 1ns/1ps
module sim_vmask_lane_unit;
  localparam int W   = 16;
  localparam int MVL = 64;
  localparam int NR  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic         start = 0;
  logic [1:0]   op = 0;
  logic [2:0]   dst_sel = 0, srca_sel = 0, srcb_sel = 0;
  logic [W-1:0] scalar = 0;
  logic         mask_en = 0;
  logic         busy, done;
  logic         vl_we = 0;
  logic [6:0]   vl_wdata = 0;
  logic [6:0]   vl_q;
  logic [MVL-1:0] mask_q;
  logic         rf_we = 0;
  logic [2:0]   rf_wreg = 0, rf_rreg = 0;
  logic [5:0]   rf_wel = 0, rf_rel = 0;
  logic [W-1:0] rf_wdata = 0;
  logic [W-1:0] rf_rdata;

  vmask_lane_unit #(.ELEM_W(W), .MVL(MVL), .NREGS(NR)) u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .dst_sel(dst_sel),
    .srca_sel(srca_sel), .srcb_sel(srcb_sel), .scalar(scalar),
    .mask_en(mask_en), .busy(busy), .done(done), .vl_we(vl_we),
    .vl_wdata(vl_wdata), .vl_q(vl_q), .mask_q(mask_q), .rf_we(rf_we),
    .rf_wreg(rf_wreg), .rf_wel(rf_wel), .rf_wdata(rf_wdata),
    .rf_rreg(rf_rreg), .rf_rel(rf_rel), .rf_rdata(rf_rdata)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  // Reference model
  logic [W-1:0]   m [NR][MVL];
  logic [MVL-1:0] mm;
  int             mvl;

  typedef struct {
    int           r;
    int           e;
    logic [W-1:0] v;
    string        tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_vl(input int v);
    @(negedge clk);
    vl_we = 1; vl_wdata = 7'(v);
    @(negedge clk);
    vl_we = 0;
    mvl = (v > MVL) ? MVL : v;
  endtask

  task automatic wr(input int r, input int e, input logic [W-1:0] v);
    @(negedge clk);
    rf_we = 1; rf_wreg = 3'(r); rf_wel = 6'(e); rf_wdata = v;
    @(negedge clk);
    rf_we = 0;
    m[r][e] = v;
  endtask

  task automatic rd(input int r, input int e, output logic [W-1:0] v);
    @(negedge clk);
    rf_rreg = 3'(r); rf_rel = 6'(e);
    @(negedge clk);
    v = rf_rdata;
  endtask

  // Driver side of the scoreboard: queue expected contents of a register
  task automatic push_reg(input int r, input string tag_in, input string tag_out, input int lim);
    for (int e = 0; e < MVL; e++) begin
      exp_t it;
      it.r = r; it.e = e; it.v = m[r][e];
      it.tag = (e < lim) ? tag_in : tag_out;
      sb.push_back(it);
    end
  endtask

  // Monitor side: pop each expectation and compare against the design
  task automatic drain();
    while (sb.size() > 0) begin
      exp_t it;
      logic [W-1:0] got;
      it = sb.pop_front();
      rd(it.r, it.e, got);
      chk(got === it.v, it.tag, got, it.v);
    end
  endtask

  task automatic chk_mask(input string tag);
    chk(mask_q === mm, tag, mask_q, mm);
  endtask

  task automatic run(input logic [1:0] o, input int d, input int a, input int b,
                     input logic [W-1:0] s, input bit men, input bit poke);
    int c, exp_c;
    @(negedge clk);
    op = o; dst_sel = 3'(d); srca_sel = 3'(a); srcb_sel = 3'(b);
    scalar = s; mask_en = men; start = 1;
    @(negedge clk);
    start = 0;
    c = 1;
    while (!done && c < 1000) begin
      if (poke && c == 3) begin start = 1; op = 2'd2; end
      else start = 0;
      @(negedge clk);
      c++;
    end
    start = 0;
    exp_c = (o[1] || mvl == 0) ? 2 : mvl + 2;
    chk(c == exp_c, "R10 done latency", c, exp_c);
    @(negedge clk);
    chk(!done && !busy, "R10 single done pulse", {done, busy}, 0);
    // model update
    if (o[1]) mm = '1;
    else begin
      for (int i = 0; i < mvl; i++) begin
        if (o == 2'd1) mm[i] = (m[a][i] != s);
        else if (!men || mm[i]) m[d][i] = m[a][i] - m[b][i];
      end
    end
  endtask

  initial begin
    logic [W-1:0] v;
    mvl = MVL;
    mm = '1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !done, "R1 idle after reset", {busy, done}, 0);
    chk(vl_q == 7'(MVL), "R1 length after reset", vl_q, MVL);
    chk(&mask_q, "R1 mask after reset", mask_q, {MVL{1'b1}});

    // Load registers 0..5
    for (int e = 0; e < MVL; e++) begin
      v = 16'(e * 731 + 5);
      if (e == 3) v = 16'h8000;
      if (e == 7) v = 16'h7fff;
      wr(0, e, v);
      wr(1, e, (e % 5 == 0) ? 16'h0 : 16'(e * 313 + 1));
      v = 16'(e * 97 + 1);
      if (e == 3) v = 16'h0001;
      if (e == 7) v = 16'hffff;
      wr(2, e, v);
      for (int r = 3; r < 6; r++) wr(r, e, 16'(e * 11 + r * 1000 + 17));
    end

    // R2 saturation
    set_vl(100);
    chk(vl_q == 7'(MVL), "R2 saturate", vl_q, MVL);
    set_vl(37);
    chk(vl_q == 7'd37, "R2 in range", vl_q, 37);
    set_vl(64);

    // R6 full unmasked subtract with wrap at elements 3 and 7
    run(2'd0, 3, 0, 2, 0, 0, 0);
    chk(m[3][3] == 16'h7fff && m[3][7] == 16'h8000, "R6 model wrap", m[3][3], 16'h7fff);
    push_reg(3, "R6 unmasked subtract", "R6 unmasked subtract", MVL);
    drain();

    // R4 compare of reg1 against zero
    run(2'd1, 0, 1, 0, 16'h0, 0, 0);
    chk_mask("R4 compare against zero");
    // R4 compare ignores mask and mask_en
    run(2'd1, 0, 2, 0, 16'(3 * 97 + 1), 1, 0);
    chk_mask("R4 compare under enabled mask");

    // R5 short length leaves upper mask bits alone
    run(2'd1, 0, 1, 0, 16'h0, 0, 0);
    set_vl(20);
    run(2'd1, 0, 0, 0, 16'(2 * 731 + 5), 0, 0);
    chk_mask("R5 compare upper bits kept");
    repeat (3) @(negedge clk);
    chk_mask("R5 mask quiet while idle");

    // R3 clear
    set_vl(64);
    run(2'd2, 0, 0, 0, 0, 0, 0);
    chk(&mask_q, "R3 clear sets all", mask_q, {MVL{1'b1}});
    run(2'd1, 0, 1, 0, 16'h0, 0, 0);
    run(2'd3, 0, 0, 0, 0, 0, 0);
    chk(&mask_q, "R3 clear alt code", mask_q, {MVL{1'b1}});

    // R11 / R7 conditional subtract, with a start poked while busy (R10)
    run(2'd1, 0, 1, 0, 16'h0, 0, 0);
    run(2'd0, 1, 1, 2, 0, 1, 1);
    chk_mask("R10 start ignored while busy");
    for (int e = 0; e < MVL; e++)
      if (e % 5 == 0) chk(m[1][e] == 16'h0, "R11 model zero kept", m[1][e], 0);
    push_reg(1, "R7 R11 masked subtract", "R7 R11 masked subtract", MVL);
    drain();

    // R7 masked subtract into another register with partial mask
    run(2'd1, 0, 4, 0, 16'(10 * 11 + 4017), 0, 0);
    run(2'd0, 5, 3, 4, 0, 1, 0);
    push_reg(5, "R7 masked element kept", "R7 masked element kept", MVL);
    drain();

    // R8 short length subtract
    run(2'd2, 0, 0, 0, 0, 0, 0);
    set_vl(30);
    run(2'd0, 4, 0, 2, 0, 0, 0);
    push_reg(4, "R8 below length written", "R8 above length kept", 30);
    drain();

    // R9 zero length
    set_vl(0);
    chk(vl_q == 7'd0, "R2 zero length", vl_q, 0);
    run(2'd0, 0, 3, 3, 0, 0, 0);
    run(2'd1, 0, 3, 0, 16'h0, 0, 0);
    chk_mask("R9 zero-length compare");
    push_reg(0, "R9 no writes", "R9 no writes", 0);
    drain();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule